// File: doc/BRIEF.md
# Toggle-Signalled Divide-by-Three Event Splitter

This block takes one input line on which every level change is an event and answers each event with exactly one level change on one of two output lines. The events are grouped in cycles of three. The first and second input events of a cycle are answered on the minor output, and the third is answered on the major output. The cycle then starts again. No line ever returns to zero between events, so a sender and a receiver can work as a handshake: the sender toggles the input, waits for either output to toggle, and then may toggle the input again.

The input may come from another clock domain. It passes through a chain of capture flops before it is compared with the last value the block has answered. A toggle that arrives while an earlier event is still in that chain breaks the handshake. Such a toggle raises a sticky error flag, but it is still counted as an event. The cycle length and the depth of the capture chain are parameters, with defaults of 3 and 2.

Top module: `toggle_div3`

## Requirements
- R1: While `rst_n` is low, and after it is released, `out_minor`, `out_major` and `proto_err` are 0 and the block is at the start of a cycle. The bench holds `in_evt` at 0 while reset is released.
- R2: Every change of `in_evt` is one event, whether it goes 0 to 1 or 1 to 0.
- R3: Each event produces a toggle of exactly one output. The toggle happens on the third rising clock edge after the edge at which the changed `in_evt` is first sampled, counting that sampling edge as the first (SYNC_STAGES+1 edges with the default of 2). Neither output changes before that edge.
- R4: The first and second events of a cycle toggle `out_minor` and leave `out_major` unchanged.
- R5: The third event of a cycle toggles `out_major` and leaves `out_minor` unchanged. The next event is then the first of a new cycle.
- R6: While `in_evt` does not change, neither output changes.
- R7: A change of `in_evt` that is sampled while an earlier event has not yet been answered sets `proto_err` to 1. That change is still counted as its own event.
- R8: Once set, `proto_err` stays 1 until reset.
- R9: Asserting reset in the middle of a cycle restarts the cycle, so the next event toggles `out_minor`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_evt | input | 1 | Input event line; every toggle is one event |
| out_minor | output | 1 | Toggles in answer to the first and second event of each cycle |
| out_major | output | 1 | Toggles in answer to the third event of each cycle |
| proto_err | output | 1 | Sticky flag for an input toggle that arrived before the previous event was answered |

## Verification
The hardest case to reach from the ports is a second input toggle that lands while the first is still in the capture chain. A well-behaved handshake partner never does this. The stimulus therefore toggles `in_evt` on two consecutive clock cycles, on purpose, without waiting for the answer. The bench then checks three things: the error flag rises, both toggles are answered one clock apart in cycle order, and the flag survives further legal traffic. The second hard case is a reset in the middle of a cycle. The bench sends five events so that the next answer would be a major toggle, resets, and expects a minor toggle instead.

// File: rtl/tdiv_pkg.sv
package tdiv_pkg;

  typedef enum logic [0:0] {
    SEL_MINOR = 1'b0,
    SEL_MAJOR = 1'b1
  } out_sel_e;

  function automatic int unsigned phase_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/tdiv_evt_capture.sv
module tdiv_evt_capture #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_line,
  output logic evt_ready,
  output logic evt_clash
);

  logic [SYNC_STAGES-1:0] stage_q, stage_d;
  logic                   acked_q, acked_d;
  logic                   in_flight;

  assign stage_d[0] = evt_line;
  generate
    for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_stage
      assign stage_d[i] = stage_q[i-1];
    end
  endgenerate

  assign in_flight = |(stage_q ^ {SYNC_STAGES{acked_q}});
  assign evt_ready = stage_q[SYNC_STAGES-1] ^ acked_q;
  assign evt_clash = (evt_line ^ stage_q[0]) & in_flight;

  always_comb begin
    acked_d = acked_q;
    if (evt_ready) acked_d = stage_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      acked_q <= 1'b0;
    end else begin
      stage_q <= stage_d;
      acked_q <= acked_d;
    end
  end

  // An event is answered once and then the answered value catches up.
  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ready |=> (acked_q == $past(stage_q[SYNC_STAGES-1]))); // R2

endmodule

// File: rtl/tdiv_phase_ctr.sv
module tdiv_phase_ctr
  import tdiv_pkg::*;
#(
  parameter int unsigned DIVIDE = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     advance,
  output out_sel_e sel
);

  localparam int unsigned PW   = phase_width(DIVIDE);
  localparam logic [PW-1:0] LAST = PW'(DIVIDE - 1);

  logic [PW-1:0] phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (advance) phase_d = (phase_q == LAST) ? '0 : phase_q + 1'b1;
  end

  assign sel = (phase_q == LAST) ? SEL_MAJOR : SEL_MINOR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= LAST); // R5
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(phase_q)); // R6

endmodule

// File: rtl/tdiv_out_toggle.sv
module tdiv_out_toggle
  import tdiv_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fire,
  input  out_sel_e sel,
  input  logic     clash,
  output logic     minor_q,
  output logic     major_q,
  output logic     err_q
);

  logic minor_d, major_d, err_d;

  always_comb begin
    minor_d = minor_q;
    major_d = major_q;
    if (fire) begin
      if (sel == SEL_MAJOR) major_d = ~major_q;
      else                  minor_d = ~minor_q;
    end
    err_d = err_q | clash;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      minor_q <= 1'b0;
      major_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      minor_q <= minor_d;
      major_q <= major_d;
      err_q   <= err_d;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R8
  AST_CLASH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    clash |=> err_q); // R7

endmodule

// File: rtl/toggle_div3.sv
module toggle_div3
  import tdiv_pkg::*;
#(
  parameter int unsigned DIVIDE      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_evt,
  output logic out_minor,
  output logic out_major,
  output logic proto_err
);

  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  logic       evt_ready, evt_clash;
  out_sel_e   sel;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  tdiv_evt_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .evt_line  (in_evt),
    .evt_ready (evt_ready),
    .evt_clash (evt_clash)
  );

  tdiv_phase_ctr #(.DIVIDE(DIVIDE)) u_phase (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .advance (evt_ready),
    .sel     (sel)
  );

  tdiv_out_toggle u_out (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .fire    (evt_ready),
    .sel     (sel),
    .clash   (evt_clash),
    .minor_q (out_minor),
    .major_q (out_major),
    .err_q   (proto_err)
  );

  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_core_n)
    evt_ready |=> $countones({out_minor ^ $past(out_minor),
                              out_major ^ $past(out_major)}) == 1); // R3
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    !evt_ready |=> ($stable(out_minor) && $stable(out_major))); // R6
  AST_MAJOR_LAST: assert property (@(posedge clk) disable iff (!rst_core_n)
    (evt_ready && sel == SEL_MAJOR) |=> (out_major != $past(out_major))); // R5
  AST_MINOR_EARLY: assert property (@(posedge clk) disable iff (!rst_core_n)
    (evt_ready && sel == SEL_MINOR) |=> (out_minor != $past(out_minor))); // R4

endmodule

// File: tb/toggle_div3_test.sv
module toggle_div3_test;

  localparam int STAGES = 2;
  localparam int LAT    = STAGES + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic in_evt;
  logic out_minor, out_major, proto_err;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  toggle_div3 #(.DIVIDE(3), .SYNC_STAGES(STAGES)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_evt    (in_evt),
    .out_minor (out_minor),
    .out_major (out_major),
    .proto_err (proto_err)
  );

  // Behavioural reference: queue of sampled input levels, answered level, phase.
  bit   samp_q[$];
  bit   m_ack, m_minor, m_major, m_err;
  int   m_phase;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q = {};
      for (int i = 0; i < STAGES; i++) samp_q.push_back(1'b0);
      m_ack = 0; m_minor = 0; m_major = 0; m_err = 0; m_phase = 0;
    end else begin
      bit busy;
      busy = 0;
      foreach (samp_q[i]) if (samp_q[i] != m_ack) busy = 1;
      if (in_evt != samp_q[0] && busy) m_err = 1;
      if (samp_q[STAGES-1] != m_ack) begin
        m_ack = samp_q[STAGES-1];
        if (m_phase == 2) m_major = ~m_major; else m_minor = ~m_minor;
        m_phase = (m_phase + 1) % 3;
      end
      samp_q.push_front(in_evt);
      void'(samp_q.pop_back());
    end
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Every-clock comparison against the reference.
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      check("R4", "out_minor vs model", out_minor, m_minor);
      check("R5", "out_major vs model", out_major, m_major);
      check("R7", "proto_err vs model", proto_err, m_err);
    end
  end

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Legal event: toggle, check no early answer, then expect the given output to toggle.
  task automatic legal_event(input bit expect_major, input string req);
    logic mi0, ma0;
    @(negedge clk);
    mi0 = out_minor; ma0 = out_major;
    in_evt = ~in_evt;
    wait_cycles(LAT - 1);
    check("R3", "no early minor", out_minor, mi0);
    check("R3", "no early major", out_major, ma0);
    @(negedge clk);
    check(req, "minor after event", out_minor, expect_major ? mi0 : ~mi0);
    check(req, "major after event", out_major, expect_major ? ~ma0 : ma0);
    wait_cycles(1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_cycles(3);
    check("R1", "minor in reset", out_minor, 1'b0);
    check("R1", "major in reset", out_major, 1'b0);
    check("R1", "err in reset", proto_err, 1'b0);
    in_evt = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    wait_cycles(4);
  endtask

  initial begin
    rst_n  = 1'b0;
    in_evt = 1'b0;
    do_reset();
    check("R1", "minor after reset", out_minor, 1'b0);
    check("R1", "major after reset", out_major, 1'b0);
    check("R1", "err after reset", proto_err, 1'b0);

    // R2: rising and falling toggles both count; two full cycles.
    for (int c = 0; c < 2; c++) begin
      legal_event(1'b0, "R4");
      legal_event(1'b0, "R4");
      legal_event(1'b1, "R5");
    end

    // R6: quiet input holds outputs.
    begin
      logic mi, ma;
      mi = out_minor; ma = out_major;
      wait_cycles(20);
      check("R6", "minor quiet", out_minor, mi);
      check("R6", "major quiet", out_major, ma);
    end
    check("R7", "no error on legal traffic", proto_err, 1'b0);

    // R9: five events leave the cycle at its third step; reset restarts it.
    legal_event(1'b0, "R2");
    legal_event(1'b0, "R2");
    legal_event(1'b1, "R2");
    legal_event(1'b0, "R2");
    legal_event(1'b0, "R2");
    do_reset();
    legal_event(1'b0, "R9");

    // R7: two toggles on consecutive cycles.
    @(negedge clk); in_evt = ~in_evt;
    @(negedge clk); in_evt = ~in_evt;
    wait_cycles(LAT + 2);
    check("R7", "clash raises error", proto_err, 1'b1);
    // Events so far after reset: 3 -> cycle restarted; answered minor+major? model compares each clock.
    legal_event(1'b0, "R7");
    legal_event(1'b0, "R7");
    legal_event(1'b1, "R7");
    wait_cycles(10);
    check("R8", "error stays set", proto_err, 1'b1);
    do_reset();
    check("R8", "reset clears error", proto_err, 1'b0);

    wait_cycles(5);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #50000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule